// File: doc/BRIEF.md
# Flash Command Interface Controller

This block decodes bus write strobes into commands for a 16-bit word-addressed flash. It also decides what a bus read returns: array contents, the status register, identification codes or query data. A program/erase sequencer runs each operation against a small behavioural word array. A busy counter stands in for the cell timing. The sequencer tracks whether an operation is running, suspended or done.

Multi-write commands are checked before they start. Block erase needs a confirm code. Word program and double-word program latch their address and data on the final write. The address space is split into 23 blocks: eight small parameter blocks and fifteen main blocks, each main block eight times the size of a parameter block. A parameter puts the parameter blocks at the low end or the high end of the space. Block 0 and block 1 are the two outermost parameter blocks. They can be locked by a write-protect input. A supply-lockout input locks every block.

Error flags in the status word stay set until a clear command is written. An erase may be suspended so that another block can be read or programmed. A program may be suspended so that other locations can be read.

Top module: `flash_cmd_ctl`

## Requirements
- R1: After reset the controller is idle and ready (`ready`=1), in array-read mode, with all error flags clear. The status word then reads 0080h. Status layout: bit7 ready, bit6 erase suspended, bit5 erase error, bit4 program error, bit3 supply error, bit2 program suspended, bit1 protection error, bit0 and the upper byte zero.
- R2: Writing 20h and then D0h erases the block that holds the second write's address, setting every word to FFFFh. If the second low byte is not D0h, the command aborts, status bits 5 and 4 are set, and reads return status.
- R3: Writing 40h and then a data word programs the addressed word to (old AND data), after PROG_CYCLES busy cycles.
- R4: Writing 30h and then two address/data writes programs both words. If the two addresses differ in any bit other than bit 0, the command aborts with status bit 4 set and no word changes.
- R5: While an operation runs, only 70h (read status) and B0h (suspend) take effect, and every read returns the status word.
- R6: A new command does not clear error flags. Writing 50h when no operation is running or suspended clears bits 5, 4, 3 and 1.
- R7: B0h suspends the running operation and sets bit 6 (erase) or bit 2 (program); `ready` reads 1. D0h resumes the operation, and reads return status afterwards.
- R8: While suspended, only D0h, FFh, 70h, 90h and 98h are accepted. 40h is accepted only when an erase is suspended and no program is pending, and it then runs a nested program.
- R9: After 90h, a read with address bit 0 low returns 0020h and with bit 0 high returns 0052h. After 98h, query offsets 10h, 11h and 12h read 0051h, 0052h and 0059h, and other offsets read 0000h.
- R10: The block map has 8 parameter blocks of PAR_WORDS words and 15 main blocks of 8*PAR_WORDS words. With TOP_BOOT=0 block 0 starts at address 0. With TOP_BOOT=1 block 0 ends at the top address. An erase touches only its own block.
- R11: A program or erase to block 0 or 1 while `wp_n`=0 aborts with bit 1 and bit 4 (program) or bit 5 (erase) set. Any program or erase while `vpp_lock`=1 aborts with bit 3 and the same bit 4 or 5. In both cases the data is left unchanged.
- R12: Asserting reset during an operation abandons it. The controller returns to ready, array-read mode with error flags clear.
- R13: An unknown command code written while idle returns the controller to array-read mode.
- R14: A B0h that arrives in the very cycle the busy counter expires is dropped. The operation completes and no suspend flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, aborts any operation |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| addr | input | AW | Word address for reads and writes (AW = log2(PAR_WORDS)+7) |
| wdata | input | 16 | Command code (low byte) or program data |
| wp_n | input | 1 | Low locks blocks 0 and 1 |
| vpp_lock | input | 1 | High locks every block |
| rdata | output | 16 | Read data for the current address and mode |
| ready | output | 1 | No operation is currently running |

## Verification
Two events can land on the same clock edge: a suspend command, and the expiry of the running operation's busy counter. The bench counts edges from the final write of a program and places B0h exactly on the expiry edge. It expects a ready status of 0080h with no suspend flag and the word programmed. It then places B0h one edge earlier and expects 0084h, followed by a normal resume. A nested program inside an erase suspend is also checked. While that program runs, status must show erase-suspended with ready low, and the suspended erase must not advance.

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl #(
  parameter int PAR_WORDS = 4,
  parameter bit TOP_BOOT = 1'b0,
  parameter int PROG_CYCLES = 8,
  parameter int ERASE_CYCLES = 16,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'h52,
  localparam int PW = $clog2(PAR_WORDS),
  localparam int AW = PW + 7,
  localparam int DEPTH = 1 << AW,
  localparam int CW = $clog2((PROG_CYCLES > ERASE_CYCLES ? PROG_CYCLES : ERASE_CYCLES) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  input  logic          wp_n,
  input  logic          vpp_lock,
  output logic [15:0]   rdata,
  output logic          ready
);
  typedef enum logic [1:0] {M_ARR, M_STS, M_SIG, M_QRY} mode_t;
  typedef enum logic [2:0] {C_IDLE, C_ERS, C_PRG, C_DW1, C_DW2} cs_t;
  localparam logic [AW-1:0] PAR_SPAN = AW'(8 * PAR_WORDS);

  logic [15:0] mem [DEPTH];
  mode_t mode;
  cs_t cs;
  logic [7:0] sr_err;
  logic p_act, p_susp, e_act, e_susp;
  logic [CW-1:0] p_cnt, e_cnt;
  logic [AW-1:0] p_a1, p_a2;
  logic [15:0] p_d1, p_d2;
  logic [4:0] e_blk;
  logic [7:0] cmd;
  logic [7:0] status;

  function automatic logic [4:0] blk_of(input logic [AW-1:0] a);
    logic [AW-1:0] x;
    x = TOP_BOOT ? ~a : a;
    if (x < PAR_SPAN) return 5'(x >> PW);
    return 5'(x >> (PW + 3)) + 5'd7;
  endfunction

  wire p_run  = p_act && !p_susp;
  wire e_run  = e_act && !e_susp;
  wire p_done = p_run && p_cnt == '0;
  wire e_done = e_run && e_cnt == '0;
  wire locked = !wp_n && blk_of(addr) < 5'd2;

  assign ready  = !p_run && !e_run;
  assign cmd    = wdata[7:0];
  assign status = {ready, e_susp, sr_err[5:3], p_susp, sr_err[1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_ARR; cs <= C_IDLE; sr_err <= '0;
      p_act <= 1'b0; p_susp <= 1'b0; e_act <= 1'b0; e_susp <= 1'b0;
      p_cnt <= '0; e_cnt <= '0; e_blk <= '0;
      p_a1 <= '0; p_a2 <= '0; p_d1 <= '0; p_d2 <= '0;
    end else begin
      if (p_run) begin
        if (p_cnt == '0) p_act <= 1'b0; else p_cnt <= p_cnt - 1'b1;
      end
      if (e_run) begin
        if (e_cnt == '0) e_act <= 1'b0; else e_cnt <= e_cnt - 1'b1;
      end
      if (wr_en) begin
        case (cs)
          C_ERS: begin
            cs <= C_IDLE; mode <= M_STS;
            if (cmd != 8'hD0) sr_err[5:4] <= 2'b11;
            else if (vpp_lock) begin sr_err[5] <= 1'b1; sr_err[3] <= 1'b1; end
            else if (locked) begin sr_err[5] <= 1'b1; sr_err[1] <= 1'b1; end
            else begin e_act <= 1'b1; e_blk <= blk_of(addr); e_cnt <= CW'(ERASE_CYCLES - 1); end
          end
          C_PRG, C_DW2: begin
            cs <= C_IDLE; mode <= M_STS;
            if (cs == C_DW2 && addr[AW-1:1] != p_a1[AW-1:1]) sr_err[4] <= 1'b1;
            else if (vpp_lock) begin sr_err[4] <= 1'b1; sr_err[3] <= 1'b1; end
            else if (locked) begin sr_err[4] <= 1'b1; sr_err[1] <= 1'b1; end
            else begin
              p_act <= 1'b1; p_cnt <= CW'(PROG_CYCLES - 1);
              p_a2 <= addr; p_d2 <= wdata;
              if (cs == C_PRG) begin p_a1 <= addr; p_d1 <= wdata; end
            end
          end
          C_DW1: begin
            p_a1 <= addr; p_d1 <= wdata; cs <= C_DW2;
          end
          default: begin
            if (!ready) begin
              if (cmd == 8'h70) mode <= M_STS;
              else if (cmd == 8'hB0) begin
                mode <= M_STS;
                if (p_run && p_cnt != '0) p_susp <= 1'b1;
                else if (e_run && e_cnt != '0) e_susp <= 1'b1;
              end
            end else if (p_susp || e_susp) begin
              case (cmd)
                8'hD0: begin
                  mode <= M_STS;
                  if (p_susp) p_susp <= 1'b0; else e_susp <= 1'b0;
                end
                8'hFF: mode <= M_ARR;
                8'h70: mode <= M_STS;
                8'h90: mode <= M_SIG;
                8'h98: mode <= M_QRY;
                8'h40: if (e_susp && !p_act) cs <= C_PRG;
                default: ;
              endcase
            end else begin
              case (cmd)
                8'hFF: mode <= M_ARR;
                8'h70: mode <= M_STS;
                8'h90: mode <= M_SIG;
                8'h98: mode <= M_QRY;
                8'h20: cs <= C_ERS;
                8'h40: cs <= C_PRG;
                8'h30: cs <= C_DW1;
                8'h50: sr_err <= '0;
                default: mode <= M_ARR;
              endcase
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (p_done) begin
        mem[p_a1] <= mem[p_a1] & p_d1;
        mem[p_a2] <= mem[p_a2] & p_d2;
      end
      if (e_done)
        for (int i = 0; i < DEPTH; i++)
          if (blk_of(AW'(i)) == e_blk) mem[i] <= '1;
    end
  end

  always_comb begin
    if (!ready) rdata = {8'h00, status};
    else begin
      case (mode)
        M_ARR: rdata = mem[addr];
        M_STS: rdata = {8'h00, status};
        M_SIG: rdata = {8'h00, addr[0] ? DEV_CODE : MFR_CODE};
        default: begin
          case (addr[7:0])
            8'h10: rdata = 16'h0051;
            8'h11: rdata = 16'h0052;
            8'h12: rdata = 16'h0059;
            default: rdata = 16'h0000;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wdata,
  input logic [15:0] rdata,
  input logic        ready,
  input logic        p_act,
  input logic        p_susp,
  input logic        e_act,
  input logic        e_susp,
  input logic [7:0]  sr_err
);
  // R5
  busy_reads_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (rdata[15:8] == 8'h00 && !rdata[7]));

  // R6
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (|($past(sr_err) & ~sr_err))) |-> $past(wr_en && wdata[7:0] == 8'h50));

  // R7
  prog_susp_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_susp |-> p_act);

  // R7
  erase_susp_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    e_susp |-> e_act);

  // R8
  nested_only_in_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_act && e_act) |-> e_susp);

  // R12
  reset_abort_chk: assert property (@(posedge clk)
    !rst_n |=> (ready && !p_act && !e_act && sr_err == 8'h00));
endmodule

bind flash_cmd_ctl flash_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
  .ready(ready), .p_act(p_act), .p_susp(p_susp), .e_act(e_act),
  .e_susp(e_susp), .sr_err(sr_err)
);

// File: tb/sim_flash_cmd_ctl.sv
module sim_flash_cmd_ctl;
  localparam int PROG_CYCLES = 8;
  localparam int AW = 9;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic wp_n = 1'b1;
  logic vpp_lock = 1'b0;
  logic [15:0] rdata, rdata1;
  logic ready, ready1;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  flash_cmd_ctl #(.PROG_CYCLES(PROG_CYCLES)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .wp_n(wp_n), .vpp_lock(vpp_lock), .rdata(rdata), .ready(ready));

  flash_cmd_ctl #(.PROG_CYCLES(PROG_CYCLES), .TOP_BOOT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .wp_n(wp_n), .vpp_lock(vpp_lock), .rdata(rdata1), .ready(ready1));

  // {op, addr, data}: op 0 = write, 1 = read and compare, 2 = wait for ready
  localparam int NV = 34;
  localparam logic [26:0] VEC [NV] = '{
    {2'd0, 9'h020, 16'h0020}, {2'd0, 9'h020, 16'h00D0}, {2'd2, 9'h000, 16'h0000},
    {2'd0, 9'h000, 16'h00FF}, {2'd1, 9'h020, 16'hFFFF}, {2'd1, 9'h03F, 16'hFFFF},
    {2'd0, 9'h021, 16'h0040}, {2'd0, 9'h021, 16'h1234}, {2'd2, 9'h000, 16'h0000},
    {2'd0, 9'h000, 16'h00FF}, {2'd1, 9'h021, 16'h1234}, {2'd0, 9'h021, 16'h0040},
    {2'd0, 9'h021, 16'hFF0F}, {2'd2, 9'h000, 16'h0000}, {2'd0, 9'h000, 16'h00FF},
    {2'd1, 9'h021, 16'h1204}, {2'd0, 9'h022, 16'h0030}, {2'd0, 9'h022, 16'hAAAA},
    {2'd0, 9'h023, 16'h5555}, {2'd2, 9'h000, 16'h0000}, {2'd0, 9'h000, 16'h00FF},
    {2'd1, 9'h022, 16'hAAAA}, {2'd1, 9'h023, 16'h5555}, {2'd0, 9'h000, 16'h0090},
    {2'd1, 9'h000, 16'h0020}, {2'd1, 9'h001, 16'h0052}, {2'd0, 9'h000, 16'h0098},
    {2'd1, 9'h010, 16'h0051}, {2'd1, 9'h012, 16'h0059}, {2'd1, 9'h013, 16'h0000},
    {2'd0, 9'h000, 16'h0070}, {2'd1, 9'h000, 16'h0080}, {2'd0, 9'h000, 16'h0077},
    {2'd1, 9'h021, 16'h1204}
  };

  function automatic string tag_of(input int i);
    if (i < 6) return "R2";
    if (i < 16) return "R3";
    if (i < 23) return "R4";
    if (i < 30) return "R9";
    if (i < 32) return "R1";
    return "R13";
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a, input logic [15:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic waitrdy(input string tag);
    int n = 0;
    while (!ready && n < 500) begin @(negedge clk); n++; end
    chk(tag, {15'd0, ready}, 16'd1);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {15'd0, ready}, 16'd1);
    wr(0, 16'h0070); rd("R1", 0, 16'h0080);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][26:25])
        2'd0: wr(VEC[i][24:16], VEC[i][15:0]);
        2'd1: rd(tag_of(i), VEC[i][24:16], VEC[i][15:0]);
        default: waitrdy(tag_of(i));
      endcase
    end

    // R2 wrong confirm code
    wr(9'h020, 16'h0020); wr(9'h020, 16'h00AA); rd("R2", 0, 16'h00B0);
    // R6 errors survive a new command, clear command resets them
    wr(0, 16'h0070); rd("R6", 0, 16'h00B0);
    wr(0, 16'h0050); wr(0, 16'h0070); rd("R6", 0, 16'h0080);

    // R5 only status and suspend accepted while busy
    wr(9'h040, 16'h0020); wr(9'h040, 16'h00D0); rd("R5", 9'h040, 16'h0000);
    wr(0, 16'h0090); wr(0, 16'h00FF); rd("R5", 0, 16'h0000);
    waitrdy("R5"); rd("R5", 0, 16'h0080);
    wr(0, 16'h00FF); rd("R5", 9'h041, 16'hFFFF);

    // R7 erase suspend, R8 nested program
    wr(9'h041, 16'h0040); wr(9'h041, 16'h00F0); waitrdy("R3");
    wr(9'h040, 16'h0020); wr(9'h040, 16'h00D0); wr(0, 16'h00B0);
    rd("R7", 0, 16'h00C0);
    wr(0, 16'h0020); wr(0, 16'h0070); rd("R8", 0, 16'h00C0);
    wr(0, 16'h00FF); rd("R7", 9'h041, 16'h00F0);
    wr(9'h021, 16'h0040); wr(9'h021, 16'h0004); rd("R8", 0, 16'h0040);
    waitrdy("R8"); rd("R8", 0, 16'h00C0);
    wr(0, 16'h00FF); rd("R8", 9'h021, 16'h0004);
    wr(0, 16'h00D0); rd("R7", 0, 16'h0000);
    waitrdy("R7"); rd("R7", 0, 16'h0080);
    wr(0, 16'h00FF); rd("R7", 9'h041, 16'hFFFF);

    // R8 program suspend refuses a new program
    wr(9'h025, 16'h0040); wr(9'h025, 16'h0000); wr(0, 16'h00B0);
    rd("R7", 0, 16'h0084);
    wr(9'h026, 16'h0040); wr(9'h026, 16'h0000); wr(0, 16'h0070);
    rd("R8", 0, 16'h0084);
    wr(0, 16'h00D0); waitrdy("R7"); wr(0, 16'h00FF);
    rd("R7", 9'h025, 16'h0000); rd("R8", 9'h026, 16'hFFFF);

    // R14 suspend on the expiry edge is dropped
    wr(9'h027, 16'h0040); wr(9'h027, 16'h00FF);
    repeat (PROG_CYCLES - 1) @(negedge clk);
    wr(0, 16'h00B0); rd("R14", 0, 16'h0080);
    wr(0, 16'h00FF); rd("R14", 9'h027, 16'h00FF);
    wr(9'h028, 16'h0040); wr(9'h028, 16'h0F0F);
    repeat (PROG_CYCLES - 2) @(negedge clk);
    wr(0, 16'h00B0); rd("R14", 0, 16'h0084);
    wr(0, 16'h00D0); waitrdy("R14"); wr(0, 16'h00FF);
    rd("R14", 9'h028, 16'h0F0F);

    // R4 double-word address mismatch
    wr(9'h029, 16'h0030); wr(9'h029, 16'h1111); wr(9'h02B, 16'h2222);
    rd("R4", 0, 16'h0090); wr(0, 16'h0050);
    wr(0, 16'h00FF); rd("R4", 9'h029, 16'hFFFF);

    // R11 protection
    wp_n = 1'b0;
    wr(0, 16'h0040); wr(0, 16'h0000); rd("R11", 0, 16'h0092); wr(0, 16'h0050);
    wr(9'h008, 16'h0040); wr(9'h008, 16'h0000); waitrdy("R11");
    wr(0, 16'h0070); rd("R11", 0, 16'h0080);
    // R10 top-boot map: highest word is lockable only in u1
    wr(9'h1FF, 16'h0040); wr(9'h1FF, 16'h0000); addr = 0; #1;
    chk("R10", rdata1, 16'h0092); chk("R10", rdata, 16'h0000);
    waitrdy("R10"); wr(0, 16'h0050);
    wp_n = 1'b1; vpp_lock = 1'b1;
    wr(9'h021, 16'h0020); wr(9'h021, 16'h00D0); rd("R11", 0, 16'h00A8);
    wr(0, 16'h00FF); rd("R11", 9'h021, 16'h0004);
    wr(0, 16'h0050); vpp_lock = 1'b0;

    // R10 parameter block granularity
    wr(9'h004, 16'h0020); wr(9'h004, 16'h00D0); waitrdy("R10");
    wr(9'h008, 16'h0020); wr(9'h008, 16'h00D0); waitrdy("R10");
    wr(9'h00C, 16'h0020); wr(9'h00C, 16'h00D0); waitrdy("R10");
    wr(9'h007, 16'h0040); wr(9'h007, 16'h1111); waitrdy("R10");
    wr(9'h00C, 16'h0040); wr(9'h00C, 16'h2222); waitrdy("R10");
    wr(9'h008, 16'h0040); wr(9'h008, 16'h3333); waitrdy("R10");
    wr(9'h00A, 16'h0020); wr(9'h00A, 16'h00D0); waitrdy("R10");
    wr(0, 16'h00FF);
    rd("R10", 9'h008, 16'hFFFF); rd("R10", 9'h00B, 16'hFFFF);
    rd("R10", 9'h007, 16'h1111); rd("R10", 9'h00C, 16'h2222);

    // R12 reset aborts an erase
    wr(9'h040, 16'h0020); wr(9'h040, 16'h00D0);
    repeat (3) @(negedge clk);
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
    chk("R12", {15'd0, ready}, 16'd1);
    rd("R12", 9'h021, 16'h0004);
    wr(0, 16'h0070); rd("R12", 0, 16'h0080);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule